// File: doc/BRIEF.md
# Sector Page-Buffer Program Controller

This block is the internal write engine of a word-wide nonvolatile memory that is reprogrammed one sector at a time. A host drives an asynchronous-style bus with active-low chip enable, write enable and output enable, plus an address and a data word. The block samples that bus on its own clock. Each write strobe deposits one word into a page buffer for the sector it targets. Once the strobes have gone quiet for a set number of cycles, the block erases the whole sector to all ones. It then writes back every buffered word. The sector ends up holding exactly the words loaded in that window, and every other word reads as all ones.

While the erase-and-program period runs, the address and data inputs are free. A read during that period does not reach the array. It returns a status word built from the last loaded data: two bits are inverted, and two other bits alternate on each successive read. Software can therefore poll for completion in either of two ways. A `busy` level and a one-cycle `done` pulse are also brought out. The storage array is a behavioural RAM inside the block. All delays are parameters counted in clock cycles. The array geometry is set by a sector-select width and a word-select width, so the full 512 x 128 arrangement is available by parameter.

Top module: `spb_top`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `dout` is 0.
- R2: A bus cycle counts as a write only while `ce_n` and `we_n` are both low and `oe_n` is high. A cycle with all three low loads nothing.
- R3: The write address is captured when the later of `ce_n`/`we_n` falls, so address changes after that point are ignored. The data word is captured from the last sampled value before the first of the two strobes rises.
- R4: Address bits [AW-1:WORD_BITS] select the sector and bits [WORD_BITS-1:0] select the word within it. Words may be loaded in any order, and each lands at its own address.
- R5: The load phase ends, and `busy` rises, once no accepted write strobe has been active for LOAD_WIN cycles. A new load that starts within that window restarts the count.
- R6: The program period first sets every word of the locked sector to 16'hFFFF, then writes the loaded words. Unloaded words read 16'hFFFF afterwards, whatever they held before, and other sectors are untouched.
- R7: The sector is locked by the first load of a window. Loads to any other sector during the same window are ignored.
- R8: A read starts when `ce_n` and `oe_n` are low with `we_n` high, and `dout` updates two cycles after the strobe is applied and then holds. While `busy`, the read returns the last loaded word with bits 15 and 7 inverted. After completion, reads return true array data.
- R9: While `busy`, bits 14 and 6 of each read result carry a toggle flag. The flag is 0 on the first read of the program period and inverts on every later read.
- R10: `busy` stays high for exactly PROG_CYCLES cycles. `done` pulses high for one cycle, in the first cycle after `busy` falls.
- R11: Writes that arrive while `busy` is high are ignored: they change neither the array nor the polled status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address: sector bits above word bits |
| din | input | DW | Write data |
| dout | output | DW | Read result, held between reads |
| busy | output | 1 | Erase-and-program period in progress |
| done | output | 1 | One-cycle pulse when programming completes |

## Verification
Assertions cover the rules that hold on every cycle. They check the exact length of the busy period and that `done` is a single pulse following it. They also check that the inverted poll bits match the last loaded word on every read during programming, that `dout` moves only after a read start, and that the last loaded word cannot change while busy. What lands in the array can only be shown by the bench's scenarios. These cover out-of-order loads, words erased to all ones, the sector lock, address and data capture around strobe edges, the load-window timing and writes rejected while busy, each confirmed by reading the array back afterwards.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_ERASE = 2'd2,
    PH_PROG  = 2'd3
  } phase_t;
endpackage

// File: rtl/spb_bus_sampler.sv
module spb_bus_sampler #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_start,
  output logic          wr_end,
  output logic          rd_start
);
  logic          s_ce_n, s_we_n, s_oe_n;
  logic [DW-1:0] s_din;
  logic          wr_prev_q, rd_prev_q;
  logic [DW-1:0] wr_data_q;
  logic          wr_act, rd_act;

  always_comb begin
    wr_act   = !s_ce_n && !s_we_n && s_oe_n;
    rd_act   = !s_ce_n && !s_oe_n && s_we_n;
    wr_start = wr_act && !wr_prev_q;
    wr_end   = !wr_act && wr_prev_q;
    rd_start = rd_act && !rd_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce_n    <= 1'b1;
      s_we_n    <= 1'b1;
      s_oe_n    <= 1'b1;
      s_addr    <= '0;
      s_din     <= '0;
      wr_prev_q <= 1'b0;
      rd_prev_q <= 1'b0;
    end else begin
      s_ce_n    <= ce_n;
      s_we_n    <= we_n;
      s_oe_n    <= oe_n;
      s_addr    <= addr;
      s_din     <= din;
      wr_prev_q <= wr_act;
      rd_prev_q <= rd_act;
    end
  end

  // data follows the bus while the write strobe is active, freezes at its end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_data_q <= '0;
    end else if (wr_act) begin
      wr_data_q <= s_din;
    end
  end

  assign wr_data = wr_data_q;
endmodule

// File: rtl/spb_page_buffer.sv
module spb_page_buffer #(
  parameter int WORD_BITS = 7,
  parameter int DW        = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 ld_en,
  input  logic [WORD_BITS-1:0] ld_word,
  input  logic [DW-1:0]        ld_data,
  input  logic [WORD_BITS-1:0] rd_word,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_loaded,
  output logic [DW-1:0]        last_data
);
  localparam int WORDS = 1 << WORD_BITS;

  logic [DW-1:0]    page_q [WORDS];
  logic [WORDS-1:0] loaded_q;
  logic [DW-1:0]    last_q;

  always_ff @(posedge clk) begin
    if (ld_en) begin
      page_q[ld_word] <= ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= '0;
      last_q   <= '0;
    end else if (clear) begin
      loaded_q <= '0;
    end else if (ld_en) begin
      loaded_q[ld_word] <= 1'b1;
      last_q            <= ld_data;
    end
  end

  assign rd_data   = page_q[rd_word];
  assign rd_loaded = loaded_q[rd_word];
  assign last_data = last_q;
endmodule

// File: rtl/spb_array.sv
module spb_array #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/spb_prog_seq.sv
module spb_prog_seq
  import spb_pkg::*;
#(
  parameter int SECT_BITS   = 4,
  parameter int WORD_BITS   = 7,
  parameter int DW          = 16,
  parameter int LOAD_WIN    = 1000,
  parameter int PROG_CYCLES = 1024
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_start,
  input  logic                           wr_end,
  input  logic [SECT_BITS+WORD_BITS-1:0] s_addr,
  input  logic [DW-1:0]                  buf_data,
  input  logic                           buf_loaded,
  output logic                           clear,
  output logic                           ld_en,
  output logic [WORD_BITS-1:0]           ld_word,
  output logic [WORD_BITS-1:0]           buf_rd_word,
  output logic                           arr_we,
  output logic [SECT_BITS+WORD_BITS-1:0] arr_waddr,
  output logic [DW-1:0]                  arr_wdata,
  output phase_t                         phase,
  output logic                           busy,
  output logic                           done
);
  localparam int WORDS = 1 << WORD_BITS;
  localparam int PCW   = $clog2(PROG_CYCLES) + 1;
  localparam int TW    = $clog2(LOAD_WIN) + 1;
  localparam logic [PCW-1:0] PC_LAST      = PCW'(PROG_CYCLES - 1);
  localparam logic [PCW-1:0] PC_ERASE_END = PCW'(WORDS - 1);
  localparam logic [PCW-1:0] PC_PROG_END  = PCW'(2 * WORDS);
  localparam logic [TW-1:0]  T_LAST       = TW'(LOAD_WIN - 1);

  phase_t               state_q, state_d;
  logic [SECT_BITS-1:0] sec_q, sec_d;
  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 acc_q, acc_d;
  logic [TW-1:0]        tmr_q, tmr_d;
  logic [PCW-1:0]       pc_q, pc_d;
  logic                 done_q, done_d;

  logic [SECT_BITS-1:0] s_sec;
  logic [WORD_BITS-1:0] s_word;
  logic                 accept;

  always_comb begin
    s_sec  = s_addr[SECT_BITS+WORD_BITS-1:WORD_BITS];
    s_word = s_addr[WORD_BITS-1:0];
    accept = wr_start && ((state_q == PH_IDLE) ||
                          ((state_q == PH_LOAD) && (s_sec == sec_q)));

    state_d = state_q;
    sec_d   = sec_q;
    word_d  = accept ? s_word : word_q;
    acc_d   = accept ? 1'b1 : (wr_end ? 1'b0 : acc_q);
    tmr_d   = '0;
    pc_d    = '0;
    done_d  = 1'b0;
    clear   = 1'b0;

    unique case (state_q)
      PH_IDLE: begin
        if (wr_start) begin
          state_d = PH_LOAD;
          sec_d   = s_sec;
          clear   = 1'b1;
        end
      end
      PH_LOAD: begin
        if (!accept && !acc_q) begin
          tmr_d = tmr_q + 1'b1;
          if (tmr_q == T_LAST) begin
            state_d = PH_ERASE;
            tmr_d   = '0;
          end
        end
      end
      PH_ERASE: begin
        pc_d = pc_q + 1'b1;
        if (pc_q == PC_ERASE_END) begin
          state_d = PH_PROG;
        end
      end
      PH_PROG: begin
        pc_d = pc_q + 1'b1;
        if (pc_q == PC_LAST) begin
          state_d = PH_IDLE;
          pc_d    = '0;
          done_d  = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  // array write port: erase pass writes ones, program pass writes loaded words
  always_comb begin
    buf_rd_word = pc_q[WORD_BITS-1:0];
    arr_waddr   = {sec_q, pc_q[WORD_BITS-1:0]};
    arr_we      = 1'b0;
    arr_wdata   = '1;
    if (state_q == PH_ERASE) begin
      arr_we = 1'b1;
    end else if (state_q == PH_PROG) begin
      arr_we    = (pc_q < PC_PROG_END) && buf_loaded;
      arr_wdata = buf_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      sec_q   <= '0;
      word_q  <= '0;
      acc_q   <= 1'b0;
      tmr_q   <= '0;
      pc_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sec_q   <= sec_d;
      word_q  <= word_d;
      acc_q   <= acc_d;
      tmr_q   <= tmr_d;
      pc_q    <= pc_d;
      done_q  <= done_d;
    end
  end

  assign ld_en   = wr_end && acc_q;
  assign ld_word = word_q;
  assign phase   = state_q;
  assign busy    = (state_q == PH_ERASE) || (state_q == PH_PROG);
  assign done    = done_q;
endmodule

// File: rtl/spb_top.sv
module spb_top
  import spb_pkg::*;
#(
  parameter int SECT_BITS   = 4,
  parameter int WORD_BITS   = 7,
  parameter int DW          = 16,
  parameter int LOAD_WIN    = 1000,
  parameter int PROG_CYCLES = 1024,
  localparam int AW         = SECT_BITS + WORD_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          busy,
  output logic          done
);
  localparam int POLL_HI = DW - 1;
  localparam int POLL_LO = DW / 2 - 1;
  localparam int TGL_HI  = DW - 2;
  localparam int TGL_LO  = DW / 2 - 2;

  logic [AW-1:0]        s_addr;
  logic [DW-1:0]        wr_data;
  logic                 wr_start, wr_end, rd_start;
  logic                 clear, ld_en;
  logic [WORD_BITS-1:0] ld_word, buf_rd_word;
  logic [DW-1:0]        buf_data, last_data;
  logic                 buf_loaded;
  logic                 arr_we;
  logic [AW-1:0]        arr_waddr;
  logic [DW-1:0]        arr_wdata, arr_rdata;
  phase_t               phase;

  logic [DW-1:0]        status_word;
  logic [DW-1:0]        dout_q, dout_d;
  logic                 tgl_q, tgl_d;

  spb_bus_sampler #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .s_addr(s_addr), .wr_data(wr_data),
    .wr_start(wr_start), .wr_end(wr_end), .rd_start(rd_start)
  );

  spb_page_buffer #(.WORD_BITS(WORD_BITS), .DW(DW)) u_page (
    .clk(clk), .rst_n(rst_n), .clear(clear), .ld_en(ld_en),
    .ld_word(ld_word), .ld_data(wr_data), .rd_word(buf_rd_word),
    .rd_data(buf_data), .rd_loaded(buf_loaded), .last_data(last_data)
  );

  spb_prog_seq #(
    .SECT_BITS(SECT_BITS), .WORD_BITS(WORD_BITS), .DW(DW),
    .LOAD_WIN(LOAD_WIN), .PROG_CYCLES(PROG_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end),
    .s_addr(s_addr), .buf_data(buf_data), .buf_loaded(buf_loaded),
    .clear(clear), .ld_en(ld_en), .ld_word(ld_word),
    .buf_rd_word(buf_rd_word), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata), .phase(phase), .busy(busy), .done(done)
  );

  spb_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(s_addr), .rdata(arr_rdata)
  );

  // status word returned while programming: inverted poll bits, toggle bits
  always_comb begin
    status_word          = last_data;
    status_word[POLL_HI] = ~last_data[POLL_HI];
    status_word[POLL_LO] = ~last_data[POLL_LO];
    status_word[TGL_HI]  = tgl_q;
    status_word[TGL_LO]  = tgl_q;
  end

  always_comb begin
    dout_d = dout_q;
    tgl_d  = tgl_q;
    if (!busy) begin
      tgl_d = 1'b0;
    end else if (rd_start) begin
      tgl_d = ~tgl_q;
    end
    if (rd_start) begin
      dout_d = busy ? status_word : arr_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      tgl_q  <= tgl_d;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          rd_start,
  input logic [DW-1:0] dout,
  input logic [DW-1:0] last_data
);
  int unsigned busy_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt_q <= 0;
    end else if (busy) begin
      busy_cnt_q <= busy_cnt_q + 1;
    end else begin
      busy_cnt_q <= 0;
    end
  end

  // R10
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt_q == PROG_CYCLES);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  // R8
  poll_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && busy) |=> (dout[DW-1] == ~$past(last_data[DW-1])) &&
                           (dout[DW/2-1] == ~$past(last_data[DW/2-1])));

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(rd_start));

  // R11
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(last_data));
endmodule

bind spb_top spb_checker #(.DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rd_start(rd_start), .dout(dout), .last_data(last_data)
);

// File: tb/tb_spb_top.sv
module tb_spb_top;
  localparam int SB  = 4;
  localparam int WB  = 7;
  localparam int DW  = 16;
  localparam int AW  = SB + WB;
  localparam int LW  = 20;
  localparam int PC  = 300;

  logic          clk, rst_n, ce_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          busy, done;

  int n_chk, n_bad;
  bit finished;

  spb_top #(.SECT_BITS(SB), .WORD_BITS(WB), .DW(DW), .LOAD_WIN(LW),
            .PROG_CYCLES(PC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [AW-1:0] mk(input int sec, input int wd);
    return AW'((sec << WB) | wd);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_word(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    d = dout;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (!busy && g < 1000) begin @(negedge clk); g++; end
    while (busy && g < 2000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_word(input logic [AW-1:0] a, input logic [DW-1:0] e,
                             input string req);
    logic [DW-1:0] r;
    read_word(a, r);
    check(r === e, req, 32'(r), 32'(e));
  endtask

  task automatic t_reset();
    check(busy === 1'b0, "R1 busy", 32'(busy), 0);
    check(done === 1'b0, "R1 done", 32'(done), 0);
    check(dout === '0, "R1 dout", 32'(dout), 0);
  endtask

  task automatic t_order_erase();
    // R4 out-of-order loads, R6 unloaded words erased
    write_word(mk(2, 5), 16'h0505);
    write_word(mk(2, 0), 16'h1000);
    write_word(mk(2, 127), 16'h7F7F);
    wait_idle();
    expect_word(mk(2, 5), 16'h0505, "R4 word5");
    expect_word(mk(2, 0), 16'h1000, "R4 word0");
    expect_word(mk(2, 127), 16'h7F7F, "R4 word127");
    expect_word(mk(2, 1), 16'hFFFF, "R6 unloaded");
    write_word(mk(2, 0), 16'h2222);
    wait_idle();
    expect_word(mk(2, 0), 16'h2222, "R6 reload");
    expect_word(mk(2, 5), 16'hFFFF, "R6 old erased");
  endtask

  task automatic t_window_len();
    int cnt = 0;
    int bcnt = 0;
    int dcnt = 0;
    write_word(mk(3, 3), 16'h0333);
    repeat (LW - 6) @(negedge clk);
    check(busy === 1'b0, "R5 early", 32'(busy), 0);
    write_word(mk(3, 4), 16'h0444);
    while (!busy && cnt < 200) begin @(negedge clk); cnt++; end
    check(cnt >= LW - 2 && cnt <= LW + 2, "R5 timeout", 32'(cnt), 32'(LW));
    while (busy && bcnt < 1000) begin
      bcnt++;
      if (done) dcnt++;
      @(negedge clk);
    end
    check(bcnt == PC, "R10 busy length", 32'(bcnt), 32'(PC));
    check(done === 1'b1 && dcnt == 0, "R10 done after busy", 32'(done), 1);
    @(negedge clk);
    check(done === 1'b0, "R10 done one cycle", 32'(done), 0);
    expect_word(mk(3, 3), 16'h0333, "R5 first kept");
    expect_word(mk(3, 4), 16'h0444, "R5 second kept");
  endtask

  task automatic t_poll();
    logic [DW-1:0] r, e;
    int g = 0;
    write_word(mk(4, 9), 16'h5A3C);
    while (!busy && g < 200) begin @(negedge clk); g++; end
    for (int i = 0; i < 4; i++) begin
      read_word(mk(4, 9), r);
      e = 16'h5A3C ^ 16'h8080;
      e[14] = i[0];
      e[6]  = i[0];
      check(r === e, "R8 R9 poll status", 32'(r), 32'(e));
    end
    // R11 write during busy ignored
    write_word(mk(4, 10), 16'h1234);
    read_word(mk(4, 10), r);
    e = (16'h5A3C ^ 16'h8080) & ~16'h4040;
    check((r & ~16'h4040) === e, "R11 status unchanged", 32'(r), 32'(e));
    check(busy === 1'b1, "R11 still busy", 32'(busy), 1);
    wait_idle();
    expect_word(mk(4, 9), 16'h5A3C, "R8 true data");
    expect_word(mk(4, 10), 16'hFFFF, "R11 busy write dropped");
  endtask

  task automatic t_lock();
    write_word(mk(6, 1), 16'hAAAA);
    wait_idle();
    write_word(mk(5, 1), 16'h1111);
    write_word(mk(6, 1), 16'h2222);
    write_word(mk(5, 2), 16'h3333);
    wait_idle();
    expect_word(mk(5, 1), 16'h1111, "R7 locked word1");
    expect_word(mk(5, 2), 16'h3333, "R7 locked word2");
    expect_word(mk(6, 1), 16'hAAAA, "R7 other sector");
  endtask

  task automatic t_strobes();
    // R2 all three low: no load
    @(negedge clk);
    addr = mk(7, 0); din = 16'hDEAD; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3 address change after fall ignored, final data used
    addr = mk(7, 1); din = 16'h0000; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = mk(7, 2); din = 16'hBEEF;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3 address at the later falling strobe
    addr = mk(7, 3); din = 16'hC0DE; we_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = mk(7, 4); ce_n = 1'b0;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (2) @(negedge clk);
    wait_idle();
    expect_word(mk(7, 0), 16'hFFFF, "R2 oe low no load");
    expect_word(mk(7, 1), 16'hBEEF, "R3 addr at fall data at rise");
    expect_word(mk(7, 2), 16'hFFFF, "R3 late addr ignored");
    expect_word(mk(7, 3), 16'hFFFF, "R3 early addr ignored");
    expect_word(mk(7, 4), 16'hC0DE, "R3 later strobe addr");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; din = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_order_erase();
    t_window_len();
    t_poll();
    t_lock();
    t_strobes();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule